// File: doc/BRIEF.md
# Debug-Link NVM Wait Sequencer

This block runs one of two polling loops over a half-duplex byte link to a debug target. The loops wait for the target's nonvolatile memory to become usable. It sits above a serial PHY. It hands command bytes to the PHY on a valid/ready transmit channel and takes response bytes from the PHY on a valid/ready receive channel. It does not build frames itself.

The **access poll** sends a one-byte control/status load aimed at the status register and reads back one byte. It repeats until the enable flag in that byte is set, or until a bounded number of attempts have failed. The **idle poll** sends a one-byte data-space load and a four-byte address, then reads back one byte. It repeats, with no bound, until the busy flag of the returned byte clears.

A start pulse launches one run, and `poll_sel` chooses which loop runs. At the end the block raises `done` for one cycle, and `ok` tells success from timeout.

Top module: `nvm_wait_seq`

## Requirements
- R1: After reset, `tx_valid`, `rx_ready`, `busy` and `done` are low.
- R2: With `poll_sel`=0 (access poll), each attempt sends exactly one byte, 0x80. That byte is the command value 0x80 ORed with status register index 0. The attempt then waits for one response byte.
- R3: An access-poll response with bit 1 set ends the run with `done`=1 and `ok`=1.
- R4: After 255 access-poll responses with bit 1 clear, the run ends with `done`=1 and `ok`=0. No further byte is sent.
- R5: With `poll_sel`=1 (idle poll), each attempt sends five bytes in this order: 0x00, then 0xCF, 0x01, 0x00, 0x01. The first byte is the command with the one-byte size code 0 in bits 3:2. The next four are address 0x010001CF, least significant byte first.
- R6: The idle poll repeats its five-byte attempt for as long as bit 7 of the response is set, with no attempt limit. A response with bit 7 clear ends the run with `ok`=1.
- R7: Transmit back-pressure works as follows. Once `tx_valid` is high, it stays high and `tx_data` stays stable until a cycle with `tx_ready` high. `tx_valid` and `rx_ready` are never high in the same cycle.
- R8: `done` is high for exactly one cycle. That cycle directly follows the clock edge that accepted the final response byte. `busy` is low from that same cycle on.
- R9: A `start` pulse while `busy` is high is ignored. The byte sequence of the run in progress does not change.
- R10: A `start` pulse in the cycle where `done` is high is accepted. A new run then begins on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch a run when idle |
| poll_sel | input | 1 | 0 = access poll, 1 = idle poll |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| ok | output | 1 | Result of the last run (1 success, 0 timeout) |
| tx_data | output | 8 | Byte offered to the PHY |
| tx_valid | output | 1 | `tx_data` is valid |
| tx_ready | input | 1 | PHY accepts the byte |
| rx_data | input | 8 | Byte received by the PHY |
| rx_valid | input | 1 | `rx_data` is valid |
| rx_ready | output | 1 | Block accepts a received byte |

## Verification
Two events can fall in the same cycle: the end-of-run `done` pulse and the acceptance of a new `start`. The bench raises `start` exactly in the cycle where `done` is seen. It then judges that `busy` rises on the next edge and that the first command byte of the new run appears.

A `start` raised during a run is also exercised. For that case, the bench checks that the command bytes that follow still match the run already in progress.

// File: rtl/nvmw_pkg.sv
package nvmw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_RECV = 2'd2
  } nvmw_state_t;

  typedef enum logic {
    POLL_ACCESS = 1'b0,
    POLL_IDLE   = 1'b1
  } nvmw_poll_t;

  localparam int unsigned ADDR_BYTES = 4;
  localparam int unsigned SEQ_BYTES  = ADDR_BYTES + 1;
endpackage

// File: rtl/nvmw_byte_sel.sv
module nvmw_byte_sel
  import nvmw_pkg::*;
#(
  parameter logic [7:0]  CMD_CSLOAD = 8'h80,
  parameter logic [3:0]  CS_INDEX   = 4'h0,
  parameter logic [7:0]  CMD_DSLOAD = 8'h00,
  parameter logic [1:0]  SIZE_CODE  = 2'd0,
  parameter logic [31:0] DATA_BASE  = 32'h0100_0000,
  parameter logic [31:0] STAT_OFS   = 32'h0000_01CF
) (
  input  nvmw_poll_t  mode,
  input  logic [2:0]  idx,
  output logic [7:0]  byte_out
);
  localparam logic [31:0] POLL_ADDR = DATA_BASE | STAT_OFS;
  localparam logic [7:0]  CS_BYTE   = CMD_CSLOAD | {4'h0, CS_INDEX};
  localparam logic [7:0]  DS_BYTE   = CMD_DSLOAD | {4'h0, SIZE_CODE, 2'b00};

  logic [7:0] seq [SEQ_BYTES];

  assign seq[0] = DS_BYTE;
  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_addr
    assign seq[g+1] = POLL_ADDR[8*g +: 8];
  end

  always_comb begin
    if (mode == POLL_ACCESS) begin
      byte_out = CS_BYTE;
    end else if (idx < 3'(SEQ_BYTES)) begin
      byte_out = seq[idx];
    end else begin
      byte_out = 8'h00;
    end
  end
endmodule

// File: rtl/nvmw_retry_ctr.sv
module nvmw_retry_ctr #(
  parameter int unsigned MAX_TRIES = 255
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic last
);
  localparam int unsigned CW = $clog2(MAX_TRIES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cnt <= '0;
    end else if (inc) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign last = (cnt == CW'(MAX_TRIES - 1));
endmodule

// File: rtl/nvmw_ctrl.sv
module nvmw_ctrl
  import nvmw_pkg::*;
#(
  parameter int unsigned EN_BIT   = 1,
  parameter int unsigned BUSY_BIT = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        poll_sel,
  input  logic        tx_ready,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  input  logic        tries_last,
  output nvmw_poll_t  mode_q,
  output logic [2:0]  idx,
  output logic        tx_valid,
  output logic        rx_ready,
  output logic        busy,
  output logic        done,
  output logic        ok,
  output logic        cnt_clr,
  output logic        cnt_inc
);
  localparam logic [2:0] LAST_IDX = 3'(SEQ_BYTES - 1);

  nvmw_state_t st;
  logic        pass;
  logic        rx_hs;
  logic        tx_hs;

  assign tx_valid = (st == ST_SEND);
  assign rx_ready = (st == ST_RECV);
  assign busy     = (st != ST_IDLE);
  assign tx_hs    = tx_valid && tx_ready;
  assign rx_hs    = rx_ready && rx_valid;
  assign pass     = (mode_q == POLL_ACCESS) ? rx_data[EN_BIT] : !rx_data[BUSY_BIT];
  assign cnt_clr  = (st == ST_IDLE) && start;
  assign cnt_inc  = rx_hs && (mode_q == POLL_ACCESS) && !pass;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      mode_q <= POLL_ACCESS;
      idx    <= '0;
      done   <= 1'b0;
      ok     <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (start) begin
            mode_q <= nvmw_poll_t'(poll_sel);
            idx    <= '0;
            st     <= ST_SEND;
          end
        end
        ST_SEND: begin
          if (tx_hs) begin
            if (mode_q == POLL_ACCESS || idx == LAST_IDX) begin
              st <= ST_RECV;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        ST_RECV: begin
          if (rx_hs) begin
            if (pass) begin
              st   <= ST_IDLE;
              done <= 1'b1;
              ok   <= 1'b1;
            end else if (mode_q == POLL_ACCESS && tries_last) begin
              st   <= ST_IDLE;
              done <= 1'b1;
              ok   <= 1'b0;
            end else begin
              idx <= '0;
              st  <= ST_SEND;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nvm_wait_seq.sv
module nvm_wait_seq
  import nvmw_pkg::*;
#(
  parameter logic [7:0]  CMD_CSLOAD = 8'h80,
  parameter logic [3:0]  CS_INDEX   = 4'h0,
  parameter int unsigned EN_BIT     = 1,
  parameter int unsigned MAX_TRIES  = 255,
  parameter logic [7:0]  CMD_DSLOAD = 8'h00,
  parameter logic [1:0]  SIZE_CODE  = 2'd0,
  parameter logic [31:0] DATA_BASE  = 32'h0100_0000,
  parameter logic [31:0] STAT_OFS   = 32'h0000_01CF,
  parameter int unsigned BUSY_BIT   = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       poll_sel,
  output logic       busy,
  output logic       done,
  output logic       ok,
  output logic [7:0] tx_data,
  output logic       tx_valid,
  input  logic       tx_ready,
  input  logic [7:0] rx_data,
  input  logic       rx_valid,
  output logic       rx_ready
);
  nvmw_poll_t mode_q;
  logic [2:0] idx;
  logic       tries_last;
  logic       cnt_clr;
  logic       cnt_inc;

  nvmw_ctrl #(
    .EN_BIT   (EN_BIT),
    .BUSY_BIT (BUSY_BIT)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .poll_sel   (poll_sel),
    .tx_ready   (tx_ready),
    .rx_valid   (rx_valid),
    .rx_data    (rx_data),
    .tries_last (tries_last),
    .mode_q     (mode_q),
    .idx        (idx),
    .tx_valid   (tx_valid),
    .rx_ready   (rx_ready),
    .busy       (busy),
    .done       (done),
    .ok         (ok),
    .cnt_clr    (cnt_clr),
    .cnt_inc    (cnt_inc)
  );

  nvmw_retry_ctr #(
    .MAX_TRIES (MAX_TRIES)
  ) u_retry (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .inc   (cnt_inc),
    .last  (tries_last)
  );

  nvmw_byte_sel #(
    .CMD_CSLOAD (CMD_CSLOAD),
    .CS_INDEX   (CS_INDEX),
    .CMD_DSLOAD (CMD_DSLOAD),
    .SIZE_CODE  (SIZE_CODE),
    .DATA_BASE  (DATA_BASE),
    .STAT_OFS   (STAT_OFS)
  ) u_bytes (
    .mode     (mode_q),
    .idx      (idx),
    .byte_out (tx_data)
  );
endmodule

// File: rtl/nvm_wait_seq_chk.sv
module nvm_wait_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic [7:0] tx_data,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       rx_valid,
  input logic       rx_ready
);
  // R7
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

  // R7
  half_duplex_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_valid && rx_ready));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !(rx_valid && rx_ready) |=> busy);

  // R10
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy);
endmodule

bind nvm_wait_seq nvm_wait_seq_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .tx_data  (tx_data),
  .tx_valid (tx_valid),
  .tx_ready (tx_ready),
  .rx_valid (rx_valid),
  .rx_ready (rx_ready)
);

// File: tb/nvm_wait_seq_test.sv
`timescale 1ns/1ps
module nvm_wait_seq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       poll_sel = 1'b0;
  logic       busy, done, ok;
  logic [7:0] tx_data;
  logic       tx_valid;
  logic       tx_ready = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic       rx_valid = 1'b0;
  logic       rx_ready;

  int vectors = 0;
  int errors  = 0;

  always #2.5 clk = ~clk;

  nvm_wait_seq uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .poll_sel (poll_sel),
    .busy     (busy),
    .done     (done),
    .ok       (ok),
    .tx_data  (tx_data),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .rx_data  (rx_data),
    .rx_valid (rx_valid),
    .rx_ready (rx_ready)
  );

  function automatic logic [7:0] exp_byte(input logic sel, input int i);
    logic [31:0] a;
    a = 32'h0100_0000 | 32'h0000_01CF;
    if (!sel) return 8'h80 | 8'h00;
    if (i == 0) return 8'h00 | (8'(0) << 2);
    return a[8*(i-1) +: 8];
  endfunction

  function automatic logic [7:0] resp(input logic sel, input logic pass);
    logic [7:0] r;
    r = 8'($urandom);
    if (!sel) r[1] = pass;
    else      r[7] = !pass;
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Consume one byte, with random back-pressure; compare its value.
  task automatic take_byte(input string req, input logic [7:0] exp, input bit poke_start);
    int gap;
    int guard;
    gap = $urandom_range(0, 2);
    for (int k = 0; k < gap; k++) begin
      if (poke_start) begin start = 1'b1; poll_sel = ~poll_sel; end
      @(negedge clk);
      start = 1'b0;
    end
    guard = 0;
    while (!tx_valid && guard < 50) begin @(negedge clk); guard++; end
    check(req, tx_data, exp);
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
  endtask

  task automatic give_resp(input logic [7:0] r);
    int guard;
    rx_data  = r;
    rx_valid = 1'b1;
    guard = 0;
    while (!rx_ready && guard < 50) begin @(negedge clk); guard++; end
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  // One run: nfail failing responses, then a passing one unless timeout_run.
  task automatic run_poll(input logic sel, input int nfail, input bit timeout_run,
                          input bit poke, input bit chain_start);
    int n;
    string rq;
    rq = sel ? "R5" : "R2";
    poll_sel = sel;
    if (!busy) begin
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    n = timeout_run ? nfail : nfail + 1;
    for (int a = 0; a < n; a++) begin
      for (int i = 0; i < (sel ? 5 : 1); i++)
        take_byte(rq, exp_byte(sel, i), poke && a == 0);
      poll_sel = sel;
      check("R7", {31'd0, tx_valid}, 32'd0);
      give_resp(resp(sel, !timeout_run && a == n - 1));
      if (a != n - 1) check("R8", {31'd0, done}, 32'd0);
    end
    check("R8", {31'd0, done}, 32'd1);
    check("R8", {31'd0, busy}, 32'd0);
    if (timeout_run) check("R4", {31'd0, ok}, 32'd0);
    else check(sel ? "R6" : "R3", {31'd0, ok}, 32'd1);
    if (chain_start) begin
      start = 1'b1;
      poll_sel = ~sel;
      @(negedge clk);
      start = 1'b0;
      check("R10", {31'd0, busy}, 32'd1);
    end else begin
      @(negedge clk);
      check("R8", {31'd0, done}, 32'd0);
      if (timeout_run) begin
        for (int k = 0; k < 4; k++) begin
          @(negedge clk);
          check("R4", {31'd0, tx_valid}, 32'd0);
        end
      end
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R1", {28'd0, tx_valid, rx_ready, busy, done}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {28'd0, tx_valid, rx_ready, busy, done}, 32'd0);

    run_poll(1'b0, 0, 1'b0, 1'b0, 1'b0);      // R3 immediate success
    run_poll(1'b1, 0, 1'b0, 1'b0, 1'b0);      // R6 immediate idle
    run_poll(1'b0, 254, 1'b0, 1'b0, 1'b0);    // R3 success on last allowed try
    run_poll(1'b0, 255, 1'b1, 1'b0, 1'b0);    // R4 timeout
    run_poll(1'b1, 300, 1'b0, 1'b0, 1'b0);    // R6 beyond the access limit
    run_poll(1'b0, 3, 1'b0, 1'b1, 1'b0);      // R9 start ignored mid-run
    run_poll(1'b1, 2, 1'b0, 1'b1, 1'b0);      // R9
    run_poll(1'b0, 1, 1'b0, 1'b0, 1'b1);      // R10 chain into idle poll
    run_poll(1'b1, 1, 1'b0, 1'b0, 1'b0);
    for (int t = 0; t < 12; t++) begin
      logic s;
      s = 1'($urandom);
      run_poll(s, $urandom_range(0, 6), 1'b0, 1'($urandom), 1'b0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule